// File: doc/BRIEF.md
# Fractional-N Peripheral Clock Divider

This block derives a peripheral clock from one of several source clocks. It counts the ticks of the selected source and emits one period for every N ticks. N is an integer plus a fraction in steps of 1/4096. With first-order noise shaping turned on, a fractional accumulator lengthens some periods by one source tick, so the average ratio is the programmed integer plus fraction. The sources arrive as clock-enable strobes in the block's own clock domain. The result is given both as a level (the divided clock) and as a one-cycle strobe that marks the end of each period.

Software programs the block through two registers on a single-cycle write bus. A write takes effect only when its top byte carries the unlock key 0x5A. The control register selects the source, the enable and the shaping order. The ratio register holds the integer divisor and the fraction. A new ratio written while the divider is running waits until the current period ends. Clearing the enable lets the current period finish before the output stops, so no short pulse is produced.

Top module: `frac_clk_div`

## Requirements
- R1: A write whose bits 31:24 differ from 0x5A changes nothing. The enable, the ratio and the error flag all keep their values.
- R2: With shaping order 0, each output period lasts DIVI selected source ticks. DIVI is the ratio register field at bits 23:12, and a field value of 0 stands for 4096.
- R3: A keyed ratio write whose DIVI field is 1 (a divisor below 2) is rejected and the old ratio is kept. `range_err` is high from the next cycle and stays high until a keyed ratio write with an in-range DIVI.
- R4: With shaping order 0 (control bits 10:9 = 0), the fraction field (ratio bits 11:0) has no effect on the period length.
- R5: With a nonzero shaping order, a 12-bit accumulator adds DIVF at the start of each period. A carry out of the accumulator lengthens that period to DIVI+1 ticks. The accumulator is cleared while the divider is idle, so after a restart with DIVI=3 and DIVF=1024 the periods run 3,3,3,4.
- R6: Control bits 3:0 select which `src_tick` bit is counted. Ticks on the other sources are ignored, and a value of NSRC or more selects no source.
- R7: `busy` is low after reset. It goes high on the clock edge after the edge that stores a keyed control write with enable (bit 4) set, while the divider is idle.
- R8: A ratio write made while `busy` is high leaves the running period unchanged. The new ratio governs the period that follows it.
- R9: After the enable is cleared, the current period runs to its full length and ends with a final strobe. `busy` falls on that same edge, and afterwards there is no strobe and `out_clk` stays low.
- R10: `out_stb` is a one-cycle pulse at the end of each period. `out_clk` is high for the first floor(L/2) ticks of a period of length L and low for the rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_tick | input | NSRC | One clock-enable strobe per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control register, 1 selects the ratio register |
| wr_data | input | 32 | Write data; bits 31:24 carry the key |
| out_clk | output | 1 | Divided clock level |
| out_stb | output | 1 | One-cycle end-of-period strobe |
| busy | output | 1 | High while the divider runs |
| range_err | output | 1 | Last keyed ratio write had an out-of-range divisor |

## Verification
A keyed write is stored at the edge that samples it, so `range_err` changes one cycle later. `busy` rises one further edge after a keyed enable. Period lengths are never timed from a write. The bench stamps every strobe with a cycle count, sampled just after the rising edge, and checks the differences between consecutive stamps, so each result is read in the cycle the strobe register is set. Checks on the held ratio and on the clean stop pick out the gap that spans the write, which must keep the old length, and the gap after it.

// File: rtl/fcd_pkg.sv
// Shared field positions and types of the fractional clock divider.
// Assumes a 32-bit write bus with the unlock key in the top byte.
package fcd_pkg;
    localparam int REG_W   = 32;
    localparam int KEY_LO  = 24;
    localparam logic [7:0] UNLOCK = 8'h5A;
    localparam int SEL_W   = 4;
    localparam int EN_BIT  = 4;
    localparam int ORD_LO  = 9;

    typedef enum logic {
        ADDR_CTRL = 1'b0,
        ADDR_DIV  = 1'b1
    } addr_e;

    typedef struct packed {
        logic [1:0]       order;
        logic             en;
        logic [SEL_W-1:0] sel;
    } ctrl_t;
endpackage

// File: rtl/fcd_regs.sv
// Key-protected register pair: control (source, enable, shaping order)
// and ratio (integer divisor, fraction). A divisor field of 1 is rejected
// and raises the error flag. Assumes INT_W + FRAC_W <= 24.
module fcd_regs
    import fcd_pkg::*;
#(
    parameter int INT_W  = 12,
    parameter int FRAC_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output ctrl_t             ctrl,
    output logic [INT_W-1:0]  stg_divi,
    output logic [FRAC_W-1:0] stg_divf,
    output logic              range_err
);
    logic             keyed;
    logic [INT_W-1:0] new_divi;

    // Decode key and divisor field of the incoming write
    always_comb begin
        keyed    = wr_en && (wr_data[REG_W-1:KEY_LO] == UNLOCK);
        new_divi = wr_data[FRAC_W +: INT_W];
    end

    // Store keyed writes; reject a divisor below two
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl      <= '0;
            stg_divi  <= INT_W'(2);
            stg_divf  <= '0;
            range_err <= 1'b0;
        end else if (keyed) begin
            if (addr_e'(wr_addr) == ADDR_CTRL) begin
                ctrl.order <= wr_data[ORD_LO +: 2];
                ctrl.en    <= wr_data[EN_BIT];
                ctrl.sel   <= wr_data[SEL_W-1:0];
            end else if (new_divi == INT_W'(1)) begin
                range_err <= 1'b1;
            end else begin
                stg_divi  <= new_divi;
                stg_divf  <= wr_data[FRAC_W-1:0];
                range_err <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fcd_period.sv
// Computes the next period length and accumulator value. A divisor of 0
// means 2**INT_W. With nonzero order the carry of acc+divf adds one tick.
module fcd_period #(
    parameter int INT_W  = 12,
    parameter int FRAC_W = 12,
    localparam int LEN_W = INT_W + 1
) (
    input  logic [FRAC_W-1:0] acc_in,
    input  logic [INT_W-1:0]  divi,
    input  logic [FRAC_W-1:0] divf,
    input  logic [1:0]        order,
    output logic [FRAC_W-1:0] acc_out,
    output logic [LEN_W-1:0]  len
);
    logic [LEN_W-1:0]  base;
    logic [FRAC_W:0]   sum;

    // Base length and first-order fractional step
    always_comb begin
        base = (divi == '0) ? (LEN_W'(1) << INT_W) : LEN_W'(divi);
        sum  = {1'b0, acc_in} + {1'b0, divf};
        if (order != 2'd0) begin
            acc_out = sum[FRAC_W-1:0];
            len     = base + LEN_W'(sum[FRAC_W]);
        end else begin
            acc_out = acc_in;
            len     = base;
        end
    end
endmodule

// File: rtl/fcd_counter.sv
// Period counter with run/idle control. It counts selected ticks, takes
// the staged ratio at each period start and stops only at a period end.
module fcd_counter #(
    parameter int INT_W  = 12,
    parameter int FRAC_W = 12,
    localparam int LEN_W = INT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic [1:0]        order,
    input  logic [INT_W-1:0]  stg_divi,
    input  logic [FRAC_W-1:0] stg_divf,
    output logic              busy,
    output logic              out_stb,
    output logic              out_clk
);
    logic              run;
    logic [LEN_W-1:0]  cnt;
    logic [LEN_W-1:0]  len;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W-1:0] nx_acc;
    logic [LEN_W-1:0]  nx_len;

    fcd_period #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_period (
        .acc_in (acc),
        .divi   (stg_divi),
        .divf   (stg_divf),
        .order  (order),
        .acc_out(nx_acc),
        .len    (nx_len)
    );

    // Start, count, reload at boundaries, stop only at a period end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            cnt     <= '0;
            len     <= LEN_W'(2);
            acc     <= '0;
            out_stb <= 1'b0;
        end else begin
            out_stb <= 1'b0;
            if (!run) begin
                if (en) begin
                    run <= 1'b1;
                    cnt <= '0;
                    len <= nx_len;
                    acc <= nx_acc;
                end
            end else if (tick) begin
                if (cnt == len - LEN_W'(1)) begin
                    out_stb <= 1'b1;
                    cnt     <= '0;
                    if (en) begin
                        len <= nx_len;
                        acc <= nx_acc;
                    end else begin
                        run <= 1'b0;
                        acc <= '0;
                    end
                end else begin
                    cnt <= cnt + LEN_W'(1);
                end
            end
        end
    end

    // Output level: high for the first half of the period
    always_comb begin
        busy    = run;
        out_clk = run && (cnt < (len >> 1));
    end
endmodule

// File: rtl/frac_clk_div.sv
// Top of the fractional clock divider: key-protected registers, source
// tick selection and the period counter. Sources are clock enables in
// the clk domain; NSRC must not exceed 16.
module frac_clk_div
    import fcd_pkg::*;
#(
    parameter int NSRC   = 4,
    parameter int INT_W  = 12,
    parameter int FRAC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_tick,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    output logic             out_clk,
    output logic             out_stb,
    output logic             busy,
    output logic             range_err
);
    ctrl_t             ctrl;
    logic [INT_W-1:0]  stg_divi;
    logic [FRAC_W-1:0] stg_divf;
    logic              sel_tick;
    logic              ctrl_en;

    fcd_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ctrl     (ctrl),
        .stg_divi (stg_divi),
        .stg_divf (stg_divf),
        .range_err(range_err)
    );

    // Pick the tick of the selected source; out-of-range gives none
    always_comb begin
        sel_tick = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (ctrl.sel == SEL_W'(i)) sel_tick = src_tick[i];
        end
        ctrl_en = ctrl.en;
    end

    fcd_counter #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sel_tick),
        .en      (ctrl_en),
        .order   (ctrl.order),
        .stg_divi(stg_divi),
        .stg_divf(stg_divf),
        .busy    (busy),
        .out_stb (out_stb),
        .out_clk (out_clk)
    );
endmodule

// File: rtl/fcd_chk.sv
// Assertion checker for frac_clk_div, attached by bind.
module fcd_chk
    import fcd_pkg::*;
#(
    parameter int INT_W  = 12,
    parameter int FRAC_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_addr,
    input logic [7:0]       wr_key,
    input logic [INT_W-1:0] wr_divi,
    input logic             busy,
    input logic             out_stb,
    input logic             range_err,
    input logic             ctrl_en,
    input logic             sel_tick
);
    // R1
    bad_key_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_key != UNLOCK) |=> $stable(range_err));
    // R3
    range_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr && wr_key == UNLOCK && wr_divi == INT_W'(1)) |=> range_err);
    // R6
    stb_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb |-> $past(sel_tick));
    // R7
    start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctrl_en));
    // R9
    stop_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> out_stb);
    // R10
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb |=> !out_stb);
endmodule

bind frac_clk_div fcd_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_key   (wr_data[31:24]),
    .wr_divi  (wr_data[FRAC_W +: INT_W]),
    .busy     (busy),
    .out_stb  (out_stb),
    .range_err(range_err),
    .ctrl_en  (ctrl_en),
    .sel_tick (sel_tick)
);

// File: tb/frac_clk_div_bench.sv
`timescale 1ns/1ps
module frac_clk_div_bench;
    localparam int CLK_P = 10;
    localparam int NS_MAX = 8192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_tick = 4'b0001;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        out_clk, out_stb, busy, range_err;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int ns = 0;
    int stamp [NS_MAX];

    frac_clk_div u_frac_clk_div (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_clk(out_clk), .out_stb(out_stb), .busy(busy), .range_err(range_err)
    );

    always #(CLK_P/2) clk = ~clk;

    // Source 1 ticks every other cycle; sources 2 and 3 stay quiet
    initial forever begin
        @(negedge clk);
        src_tick[1] = ~src_tick[1];
    end

    // Strobe monitor: stamp every strobe just after the rising edge
    initial forever begin
        @(posedge clk);
        #1;
        cyc++;
        if (out_stb && ns < NS_MAX) begin
            stamp[ns] = cyc;
            ns++;
        end
    end

    initial begin
        #(CLK_P * 150000);
        bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrlw(input logic [7:0] key, input logic [3:0] sel,
                                          input logic en, input logic [1:0] ord);
        return {key, 13'b0, ord, 4'b0, en, sel};
    endfunction

    function automatic logic [31:0] divw(input logic [7:0] key, input int di, input int df);
        return {key, di[11:0], df[11:0]};
    endfunction

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_n(input int k);
        int target = ns + k;
        for (int t = 0; t < 20000 && ns < target; t++) @(negedge clk);
    endtask

    function automatic int gap(input int i);
        if (i < 1 || i >= ns) return -1;
        return stamp[i] - stamp[i-1];
    endfunction

    task automatic stop_div();
        wr(1'b0, ctrlw(8'h5A, 4'd0, 1'b0, 2'd0));
        for (int t = 0; t < 10000 && busy; t++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R7 reset busy", busy, 0);
        chk("R3 reset err", range_err, 0);
        chk("R10 reset stb", out_stb, 0);
        chk("R10 reset clk", out_clk, 0);
    endtask

    task automatic t_key();
        int n0 = ns;
        wr(1'b0, ctrlw(8'h00, 4'd0, 1'b1, 2'd0));
        repeat (20) @(negedge clk);
        chk("R1 bad key enable busy", busy, 0);
        chk("R1 bad key enable strobes", ns - n0, 0);
    endtask

    task automatic t_int();
        int hi = 0;
        int b;
        wr(1'b1, divw(8'h5A, 5, 0));
        wr(1'b0, ctrlw(8'h5A, 4'd0, 1'b1, 2'd0));
        chk("R7 busy not yet", busy, 0);
        @(negedge clk);
        chk("R7 busy after start", busy, 1);
        wait_n(1);
        b = ns;
        wait_n(3);
        chk("R2 gap5 a", gap(b), 5);
        chk("R2 gap5 b", gap(b+1), 5);
        chk("R2 gap5 c", gap(b+2), 5);
        wait_n(1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (out_clk) hi++;
        end
        chk("R10 high ticks of 5", hi, 2);
        chk("R10 strobe at period end", out_stb, 1);
    endtask

    task automatic t_ord0();
        int b;
        wr(1'b1, divw(8'h5A, 3, 2048));
        wait_n(2);
        b = ns;
        wait_n(4);
        for (int i = 0; i < 4; i++) chk("R4 fraction ignored", gap(b+i), 3);
    endtask

    task automatic t_ord1();
        int b, s = 0, okv = 1;
        wr(1'b0, ctrlw(8'h5A, 4'd0, 1'b1, 2'd1));
        wait_n(2);
        b = ns;
        wait_n(4);
        for (int i = 0; i < 4; i++) begin
            s += gap(b+i);
            if (gap(b+i) != 3 && gap(b+i) != 4) okv = 0;
        end
        chk("R5 half fraction sum of 4", s, 14);
        chk("R5 half fraction lengths 3 or 4", okv, 1);
    endtask

    task automatic t_restart();
        int b;
        stop_div();
        wr(1'b1, divw(8'h5A, 3, 1024));
        wr(1'b0, ctrlw(8'h5A, 4'd0, 1'b1, 2'd1));
        wait_n(1);
        b = ns;
        wait_n(3);
        chk("R5 restart gap 2", gap(b), 3);
        chk("R5 restart gap 3", gap(b+1), 3);
        chk("R5 restart gap 4", gap(b+2), 4);
    endtask

    task automatic t_held();
        int b;
        stop_div();
        wr(1'b1, divw(8'h5A, 10, 0));
        wr(1'b0, ctrlw(8'h5A, 4'd0, 1'b1, 2'd0));
        wait_n(2);
        b = ns;
        repeat (3) @(negedge clk);
        wr(1'b1, divw(8'h5A, 4, 0));
        wait_n(2);
        chk("R8 running period kept", gap(b), 10);
        chk("R8 new ratio next period", gap(b+1), 4);
    endtask

    task automatic t_stop();
        int b, n0, hi = 0;
        wr(1'b1, divw(8'h5A, 8, 0));
        wait_n(2);
        b = ns;
        repeat (2) @(negedge clk);
        wr(1'b0, ctrlw(8'h5A, 4'd0, 1'b0, 2'd0));
        wait_n(1);
        chk("R9 final period full", gap(b), 8);
        chk("R9 busy falls with last strobe", busy, 0);
        n0 = ns;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (out_clk) hi++;
        end
        chk("R9 no strobe after stop", ns - n0, 0);
        chk("R9 clock low after stop", hi, 0);
    endtask

    task automatic t_range();
        int b;
        wr(1'b1, divw(8'h5A, 1, 0));
        chk("R3 err raised", range_err, 1);
        wr(1'b0, ctrlw(8'h5A, 4'd0, 1'b1, 2'd0));
        wait_n(1);
        b = ns;
        wait_n(2);
        chk("R3 old ratio kept a", gap(b), 8);
        chk("R3 old ratio kept b", gap(b+1), 8);
        wr(1'b1, divw(8'h5A, 6, 0));
        chk("R3 err cleared", range_err, 0);
        wait_n(2);
        wr(1'b1, divw(8'h33, 2, 0));
        wr(1'b1, divw(8'h00, 1, 0));
        chk("R1 bad key no err", range_err, 0);
        wait_n(1);
        b = ns;
        wait_n(2);
        chk("R1 bad key ratio a", gap(b), 6);
        chk("R1 bad key ratio b", gap(b+1), 6);
        stop_div();
    endtask

    task automatic t_sel();
        int b;
        wr(1'b1, divw(8'h5A, 4, 0));
        wr(1'b0, ctrlw(8'h5A, 4'd1, 1'b1, 2'd0));
        wait_n(1);
        b = ns;
        wait_n(2);
        chk("R6 source 1 half rate a", gap(b), 8);
        chk("R6 source 1 half rate b", gap(b+1), 8);
        wr(1'b0, ctrlw(8'h5A, 4'd2, 1'b1, 2'd0));
        wait_n(1);
        b = ns;
        repeat (40) @(negedge clk);
        chk("R6 quiet source no strobe", ns - b, 0);
        wr(1'b0, ctrlw(8'h5A, 4'd0, 1'b1, 2'd0));
        stop_div();
    endtask

    task automatic t_max();
        int b;
        wr(1'b1, divw(8'h5A, 0, 0));
        wr(1'b0, ctrlw(8'h5A, 4'd0, 1'b1, 2'd0));
        wait_n(1);
        b = ns;
        wait_n(1);
        chk("R2 field 0 is 4096", gap(b), 4096);
        stop_div();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_key();
        t_int();
        t_ord0();
        t_ord1();
        t_restart();
        t_held();
        t_stop();
        t_range();
        t_sel();
        t_max();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule